// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies two signed two's-complement operands of `WIDTH` bits over several clock cycles using radix-2 Booth recoding. A one-cycle `start` request in the idle state captures the multiplicand and the multiplier. The block then performs one recoded step per clock for exactly `WIDTH` clocks. Each step adds the multiplicand, subtracts it, or leaves the upper half alone, and then shifts the whole working register right by one bit with the sign kept. When the last step is done, the block raises a one-cycle `done` pulse. The `2*WIDTH`-bit signed product is then available on `product`.

The upper working register carries one guard bit. For this reason the most negative multiplicand produces no intermediate overflow. A `start` request that arrives while a multiplication is in progress is dropped. After completion the product stays on the output until the next accepted start.

Top module: `booth_seq_mult`

## Requirements
- R1: After a synchronous active-low reset, `busy` is 0, `done` is 0 and `product` is all zeros.
- R2: When `start` is 1 while the block is not busy, the operands are captured at that clock edge and `busy` reads 1 from the next cycle onward.
- R3: Each step recodes the multiplier bit pair (current LSB, previous LSB), where the previous LSB is 0 before the first step. Pair 1,0 subtracts the multiplicand from the upper half. Pair 0,1 adds it. Pairs 0,0 and 1,1 leave the upper half unchanged. Multipliers of all ones and of alternating bits must give correct products.
- R4: After each step the working register {upper, multiplier, previous LSB} shifts right arithmetically by one bit, and the sign of the upper half is replicated. As a result, negative products come out correctly sign-extended.
- R5: Exactly `WIDTH` steps run. `busy` stays 1 for exactly `WIDTH` cycles, and `done` is 1 for exactly one cycle, the cycle right after `busy` falls. `busy` and `done` are never 1 together.
- R6: On `done`, `product` equals the signed product of `multiplicand` and `multiplier` as a `2*WIDTH`-bit two's-complement value (for example, with WIDTH=4, 1011 times 0011 gives 11110001).
- R7: The most negative multiplicand (1000 at WIDTH=4) gives a correct product with every multiplier, including 1000 times 1000 = 01000000.
- R8: A `start` that arrives while `busy` is 1 is ignored: the operands on the inputs at that moment do not affect the result, and the timing of `done` does not change.
- R9: While the block is idle and `start` is 0, `product` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request to begin a multiplication; honoured only when idle |
| multiplicand | input | WIDTH | Signed multiplicand, captured on an accepted start |
| multiplier | input | WIDTH | Signed multiplier, captured on an accepted start |
| busy | output | 1 | High while recoding steps are running |
| done | output | 1 | One-cycle pulse after the last step |
| product | output | 2*WIDTH | Signed product, valid from `done` until the next accepted start |

## Verification
The product is tried on all 256 operand pairs at WIDTH=4. Several patterns are also run on their own:
- The worked example -5 times 3 tests the basic subtract, add and shift sequence.
- An all-ones multiplier runs one subtract followed by only plain shifts, so it separates the 1,1 no-operation path from an add.
- Alternating multiplier bits force a subtract or an add on every step, which exposes a swapped recoding.
- The most negative multiplicand, together with the guard bit, shows whether the upper half overflows.

A second start issued while busy, carrying different operands, shows whether the block captures operands only when idle. Changing the inputs after `done` shows whether the result holds.

// File: rtl/booth_pkg.sv
// Shared types for the sequential Booth multiplier.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package booth_pkg;
    // Operation chosen by the recoder for one step.
    typedef enum logic [1:0] {
        OP_KEEP = 2'd0,
        OP_ADD  = 2'd1,
        OP_SUB  = 2'd2
    } booth_op_e;

    // Controller state.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } booth_state_e;
endpackage

// File: rtl/booth_recode.sv
// Radix-2 Booth recoder: maps the pair (current LSB, previous LSB)
// of the multiplier to keep / add / subtract.
// Assumes the caller supplies the previous LSB, which is 0 before the first step.
module booth_recode
    import booth_pkg::*;
(
    input  logic      lsb_now,
    input  logic      lsb_prev,
    output booth_op_e op
);
    // Decode the bit pair into an operation.
    always_comb begin
        unique case ({lsb_now, lsb_prev})
            2'b10:   op = OP_SUB;
            2'b01:   op = OP_ADD;
            default: op = OP_KEEP;
        endcase
    end
endmodule

// File: rtl/booth_addsub.sv
// Guarded add/subtract for the upper half of the working register.
// Both operands are ACC_W bits wide, already sign-extended by one guard bit,
// so that the most negative multiplicand cannot overflow.
module booth_addsub
    import booth_pkg::*;
#(
    parameter int ACC_W = 5
) (
    input  logic [ACC_W-1:0] acc,
    input  logic [ACC_W-1:0] mcand,
    input  booth_op_e        op,
    output logic [ACC_W-1:0] result
);
    // Select among keep, sum and difference.
    always_comb begin
        unique case (op)
            OP_ADD:  result = acc + mcand;
            OP_SUB:  result = acc - mcand;
            default: result = acc;
        endcase
    end
endmodule

// File: rtl/booth_seq_ctrl.sv
// Step controller: accepts start only when idle, counts WIDTH steps down
// and raises a one-cycle done pulse after the last one.
// Assumes WIDTH >= 1.
module booth_seq_ctrl
    import booth_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);
    localparam int CNT_W = $clog2(WIDTH + 1);
    localparam logic [CNT_W-1:0] STEPS = CNT_W'(WIDTH);

    booth_state_e     state_q;
    logic [CNT_W-1:0] steps_left_q;
    logic             last_step;

    // Derive the control strobes from the state.
    always_comb begin
        load      = start && (state_q == ST_IDLE);
        step      = (state_q == ST_RUN);
        last_step = step && (steps_left_q == CNT_W'(1));
        busy      = step;
    end

    // Advance the state and the remaining-step counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            steps_left_q <= '0;
        end else if (load) begin
            state_q      <= ST_RUN;
            steps_left_q <= STEPS;
        end else if (step) begin
            steps_left_q <= steps_left_q - CNT_W'(1);
            if (last_step) state_q <= ST_IDLE;
        end
    end

    // Register the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= last_step;
    end
endmodule

// File: rtl/booth_seq_mult.sv
// Sequential radix-2 Booth signed multiplier, top level.
// Holds the guarded upper half, the multiplier register, the previous-LSB bit
// and the multiplicand. Each busy cycle performs one add/subtract together with
// an arithmetic right shift. Product = {upper[WIDTH-1:0], multiplier register}.
// Assumes two's-complement operands; the product always fits in 2*WIDTH bits.
module booth_seq_mult
    import booth_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [WIDTH-1:0]   multiplicand,
    input  logic [WIDTH-1:0]   multiplier,
    output logic               busy,
    output logic               done,
    output logic [2*WIDTH-1:0] product
);
    localparam int ACC_W = WIDTH + 1;

    logic [ACC_W-1:0] upper_q;
    logic [WIDTH-1:0] mplr_q;
    logic             prev_lsb_q;
    logic [ACC_W-1:0] mcand_q;
    logic [ACC_W-1:0] upper_next;
    booth_op_e        step_op;
    logic             load;
    logic             step;

    booth_seq_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk  (clk),
        .rst_n(rst_n),
        .start(start),
        .load (load),
        .step (step),
        .busy (busy),
        .done (done)
    );

    booth_recode u_recode (
        .lsb_now (mplr_q[0]),
        .lsb_prev(prev_lsb_q),
        .op      (step_op)
    );

    booth_addsub #(.ACC_W(ACC_W)) u_addsub (
        .acc   (upper_q),
        .mcand (mcand_q),
        .op    (step_op),
        .result(upper_next)
    );

    // Load the operands, or add/subtract and arithmetic-shift the working register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper_q    <= '0;
            mplr_q     <= '0;
            prev_lsb_q <= 1'b0;
            mcand_q    <= '0;
        end else if (load) begin
            upper_q    <= '0;
            mplr_q     <= multiplier;
            prev_lsb_q <= 1'b0;
            mcand_q    <= {multiplicand[WIDTH-1], multiplicand};
        end else if (step) begin
            upper_q    <= {upper_next[ACC_W-1], upper_next[ACC_W-1:1]};
            mplr_q     <= {upper_next[0], mplr_q[WIDTH-1:1]};
            prev_lsb_q <= mplr_q[0];
        end
    end

    // Present the low 2*WIDTH bits of the working register.
    always_comb product = {upper_q[WIDTH-1:0], mplr_q};
endmodule

// File: rtl/booth_seq_mult_chk.sv
// Protocol checker for booth_seq_mult, attached with bind.
// Counts busy cycles locally so the step window does not depend on $past depth.
module booth_seq_mult_chk #(
    parameter int WIDTH = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               busy,
    input logic               done,
    input logic [2*WIDTH-1:0] product
);
    localparam int RUN_W = $clog2(WIDTH + 2);

    logic [RUN_W-1:0] run_len_q;

    // Measure the length of the current busy stretch.
    always_ff @(posedge clk) begin
        if (!rst_n)    run_len_q <= '0;
        else if (busy) run_len_q <= run_len_q + RUN_W'(1);
        else           run_len_q <= '0;
    end

    assert_start_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    assert_step_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_len_q == RUN_W'(WIDTH)));

    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    assert_done_after_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(product));
endmodule

bind booth_seq_mult booth_seq_mult_chk #(.WIDTH(WIDTH)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .product(product)
);

// File: tb/booth_seq_mult_tb.sv
`timescale 1ns/1ps
module booth_seq_mult_tb;
    localparam int W = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [W-1:0]   mcand = '0;
    logic [W-1:0]   mplr = '0;
    logic           busy;
    logic           done;
    logic [2*W-1:0] product;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    booth_seq_mult #(.WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .multiplicand(mcand), .multiplier(mplr),
        .busy(busy), .done(done), .product(product)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
        int sa = $signed(a);
        int sb = $signed(b);
        return (2*W)'(sa * sb);
    endfunction

    // Start one multiplication and check timing and result; optional intruding start.
    task automatic run_one(input logic [W-1:0] a, input logic [W-1:0] b,
                           input string req, input bit full, input bit intrude);
        @(negedge clk);
        mcand = a; mplr = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (full) check(busy === 1'b1, "R2", "busy after start", busy, 1);
        for (int i = 1; i < W; i++) begin
            if (intrude && i == 1) begin
                mcand = ~a; mplr = ~b; start = 1'b1;
            end
            @(negedge clk);
            start = 1'b0;
            if (full) check(busy === 1'b1 && done === 1'b0, "R5", "busy during steps", busy, 1);
        end
        @(negedge clk);
        if (full) begin
            check(busy === 1'b0, "R5", "busy after last step", busy, 0);
            check(done === 1'b1, "R5", "done pulse", done, 1);
        end
        check(product === ref_mul(a, b), req, "product", product, ref_mul(a, b));
        if (full) begin
            @(negedge clk);
            check(done === 1'b0, "R5", "done single cycle", done, 0);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(busy === 1'b0 && done === 1'b0, "R1", "status after reset", {busy, done}, 0);
        check(product === '0, "R1", "product after reset", product, 0);
    endtask

    task automatic t_example();
        run_one(4'b1011, 4'b0011, "R6", 1'b1, 1'b0);
        check(product === 8'b1111_0001, "R6", "-5*3 pattern", product, 8'hF1);
    endtask

    task automatic t_recode();
        run_one(4'b0011, 4'b1111, "R3", 1'b1, 1'b0);
        run_one(4'b0101, 4'b0101, "R3", 1'b1, 1'b0);
        run_one(4'b0110, 4'b1010, "R3", 1'b1, 1'b0);
        run_one(4'b0111, 4'b1001, "R4", 1'b1, 1'b0);
        run_one(4'b1001, 4'b0111, "R4", 1'b1, 1'b0);
    endtask

    task automatic t_most_neg();
        run_one(4'b1000, 4'b1000, "R7", 1'b1, 1'b0);
        check(product === 8'b0100_0000, "R7", "-8*-8", product, 64);
        run_one(4'b1000, 4'b0111, "R7", 1'b1, 1'b0);
        run_one(4'b1000, 4'b1111, "R7", 1'b1, 1'b0);
    endtask

    task automatic t_busy_start();
        run_one(4'b0110, 4'b1101, "R8", 1'b1, 1'b1);
    endtask

    task automatic t_hold();
        logic [2*W-1:0] kept;
        run_one(4'b1101, 4'b0101, "R9", 1'b1, 1'b0);
        kept = product;
        mcand = 4'b0111; mplr = 4'b0111;
        repeat (3) @(negedge clk);
        check(product === kept, "R9", "product held while idle", product, kept);
        check(busy === 1'b0, "R9", "stays idle without start", busy, 0);
    endtask

    task automatic t_exhaustive();
        for (int a = 0; a < (1 << W); a++)
            for (int b = 0; b < (1 << W); b++)
                run_one(W'(a), W'(b), "R6", 1'b0, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_example();
        t_recode();
        t_most_neg();
        t_busy_start();
        t_hold();
        t_exhaustive();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule